// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns an operand-addressing request into a memory address in two steps. First it forms a 16-bit effective address from one of twelve mode patterns. A pattern adds any mix of a base register (general base or base pointer), one index register (source or destination) and a signed displacement. Then it picks a segment register from the access type, the addressing mode and an optional override. It shifts that segment value left by four bits and adds the effective address, which gives a 20-bit physical address in a one-megabyte space.

A caller places the mode, register values, displacement bytes, access type and override on the inputs and pulses `start_i`. On the next clock the unit shows the registered effective address, physical address, address-valid flag and chosen segment code, and raises `done_o` for that one cycle. The results hold until the next start. Two modes (immediate and register) name no memory operand. For these the unit reports no valid address.

Top module: `seg_agu`

## Requirements
- R1: `pa_o` equals (segment value × 16 + `ea_o`) modulo 2^20. A sum past 0xFFFFF wraps to the low end of the space.
- R2: The effective-address sum wraps modulo 2^16 before the segment is added.
- R3: When `disp_wide_i`=0, a displacement-using mode (codes 3, 6, 7, 9, 10) uses `disp_lo_i` sign-extended to 16 bits. When `disp_wide_i`=1 it uses {`disp_hi_i`,`disp_lo_i`}. Direct mode (code 2) always uses the full 16-bit {`disp_hi_i`,`disp_lo_i`}.
- R4: Mode codes give the effective address as follows: 2 disp; 3 idx+disp; 4 idx; 5 bx; 6 bx+disp; 7 bx+idx+disp; 8 bx+idx; 9 bp+disp; 10 bp+idx+disp; 11 bp+idx.
- R5: The index term is `si_i` when `idx_sel_i`=0 and `di_i` when `idx_sel_i`=1.
- R6: Access type 1 (fetch) always uses the code segment (segment code 1). The override is ignored.
- R7: Access type 2 (stack) always uses the stack segment (code 2). Access type 3 (string destination) always uses the extra segment (code 0). Both ignore the override.
- R8: Access type 0 (data) defaults to the data segment (code 3). Modes 9 to 11, which use the base pointer, default to the stack segment (code 2).
- R9: With `ovr_en_i`=1, a data access whose default is the data segment uses segment `ovr_seg_i` (0 extra, 1 code, 2 stack, 3 data). A base-pointer default is not overridden.
- R10: Mode codes 0, 1 and 12–15 give `addr_vld_o`=0 with `ea_o` and `pa_o` at zero. All other codes give `addr_vld_o`=1.
- R11: Results and a one-cycle `done_o` appear on the clock edge after `start_i` is sampled high. Without a start, `done_o` is low and the results hold.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Compute request, sampled each rising edge |
| mode_i | input | 4 | Addressing-mode code |
| idx_sel_i | input | 1 | Index choice: 0 source, 1 destination |
| bx_i | input | 16 | General base register |
| bp_i | input | 16 | Base-pointer register |
| si_i | input | 16 | Source index register |
| di_i | input | 16 | Destination index register |
| disp_lo_i | input | 8 | Displacement low byte |
| disp_hi_i | input | 8 | Displacement high byte |
| disp_wide_i | input | 1 | 1: 16-bit displacement, 0: 8-bit sign-extended |
| acc_i | input | 2 | Access type: 0 data, 1 fetch, 2 stack, 3 string destination |
| ovr_en_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| es_i | input | 16 | Extra segment value |
| cs_i | input | 16 | Code segment value |
| ss_i | input | 16 | Stack segment value |
| ds_i | input | 16 | Data segment value |
| ea_o | output | 16 | Registered effective address |
| pa_o | output | 20 | Registered physical address |
| addr_vld_o | output | 1 | Registered result names a memory operand |
| seg_used_o | output | 2 | Registered segment code used |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Every result of this block passes through exactly one register. The effective address, physical address, valid flag and segment code are therefore due on the first rising edge after `start_i` is sampled, together with `done_o`. The bench changes inputs and raises `start_i` on a falling edge, waits one rising edge, and reads all outputs on the next falling edge, when `done_o` must be high. It then changes the inputs with no start and reads again one cycle later. This confirms that `done_o` has dropped and that the results have held.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    typedef enum logic [3:0] {
        AM_IMM       = 4'd0,
        AM_REG       = 4'd1,
        AM_DIRECT    = 4'd2,
        AM_IDX_DSP   = 4'd3,
        AM_IDX       = 4'd4,
        AM_BX        = 4'd5,
        AM_BX_DSP    = 4'd6,
        AM_BX_IDX_DSP= 4'd7,
        AM_BX_IDX    = 4'd8,
        AM_BP_DSP    = 4'd9,
        AM_BP_IDX_DSP= 4'd10,
        AM_BP_IDX    = 4'd11
    } amode_e;

    typedef enum logic [1:0] {
        ACC_DATA   = 2'd0,
        ACC_FETCH  = 2'd1,
        ACC_STACK  = 2'd2,
        ACC_STRDST = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    localparam int NUM_SEGS = 4;

endpackage

// File: rtl/seg_agu_ea.sv
module seg_agu_ea
    import seg_agu_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int DSP_N = 8
) (
    input  logic [3:0]             mode_i,
    input  logic                   idx_sel_i,
    input  logic [OFF_W-1:0]       bx_i,
    input  logic [OFF_W-1:0]       bp_i,
    input  logic [OFF_W-1:0]       si_i,
    input  logic [OFF_W-1:0]       di_i,
    input  logic [DSP_N-1:0]       disp_lo_i,
    input  logic [OFF_W-DSP_N-1:0] disp_hi_i,
    input  logic                   disp_wide_i,
    output logic [OFF_W-1:0]       ea_o,
    output logic                   addr_ok_o,
    output logic                   bp_base_o
);
    localparam int EXT_W = OFF_W - DSP_N;

    logic [OFF_W-1:0] idx_val;
    logic [OFF_W-1:0] dsp_narrow;
    logic [OFF_W-1:0] dsp_full;
    logic [OFF_W-1:0] dsp_sel;
    logic             use_bx, use_bp, use_idx, use_dsp, force_full;
    logic [OFF_W-1:0] base_term, idx_term, dsp_term;

    assign idx_val    = idx_sel_i ? di_i : si_i;
    assign dsp_narrow = {{EXT_W{disp_lo_i[DSP_N-1]}}, disp_lo_i};
    assign dsp_full   = {disp_hi_i, disp_lo_i};
    assign dsp_sel    = (disp_wide_i || force_full) ? dsp_full : dsp_narrow;

    always_comb begin
        use_bx     = 1'b0;
        use_bp     = 1'b0;
        use_idx    = 1'b0;
        use_dsp    = 1'b0;
        force_full = 1'b0;
        addr_ok_o  = 1'b1;
        case (mode_i)
            AM_DIRECT:     begin use_dsp = 1'b1; force_full = 1'b1; end
            AM_IDX_DSP:    begin use_idx = 1'b1; use_dsp = 1'b1; end
            AM_IDX:        begin use_idx = 1'b1; end
            AM_BX:         begin use_bx = 1'b1; end
            AM_BX_DSP:     begin use_bx = 1'b1; use_dsp = 1'b1; end
            AM_BX_IDX_DSP: begin use_bx = 1'b1; use_idx = 1'b1; use_dsp = 1'b1; end
            AM_BX_IDX:     begin use_bx = 1'b1; use_idx = 1'b1; end
            AM_BP_DSP:     begin use_bp = 1'b1; use_dsp = 1'b1; end
            AM_BP_IDX_DSP: begin use_bp = 1'b1; use_idx = 1'b1; use_dsp = 1'b1; end
            AM_BP_IDX:     begin use_bp = 1'b1; use_idx = 1'b1; end
            default:       begin addr_ok_o = 1'b0; end
        endcase
    end

    assign base_term = use_bx ? bx_i : (use_bp ? bp_i : '0);
    assign idx_term  = use_idx ? idx_val : '0;
    assign dsp_term  = use_dsp ? dsp_sel : '0;
    // Truncation to OFF_W bits gives the modulo-2^16 wrap
    assign ea_o      = base_term + idx_term + dsp_term;
    assign bp_base_o = use_bp;

endmodule

// File: rtl/seg_agu_segsel.sv
module seg_agu_segsel
    import seg_agu_pkg::*;
(
    input  logic [1:0] acc_i,
    input  logic       ovr_en_i,
    input  logic [1:0] ovr_seg_i,
    input  logic       bp_base_i,
    output logic [1:0] seg_o
);
    always_comb begin
        case (acc_i)
            ACC_FETCH:  seg_o = SEG_CS;
            ACC_STACK:  seg_o = SEG_SS;
            ACC_STRDST: seg_o = SEG_ES;
            default: begin
                if (bp_base_i)     seg_o = SEG_SS;
                else if (ovr_en_i) seg_o = ovr_seg_i;
                else               seg_o = SEG_DS;
            end
        endcase
    end
endmodule

// File: rtl/seg_agu_pa.sv
module seg_agu_pa #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg_val_i,
    input  logic [OFF_W-1:0]       ea_i,
    output logic [SEG_W+SHIFT-1:0] pa_o
);
    localparam int PA_W = SEG_W + SHIFT;

    logic [PA_W-1:0] seg_scaled;
    logic [PA_W-1:0] ea_ext;

    assign seg_scaled = {seg_val_i, {SHIFT{1'b0}}};
    assign ea_ext     = PA_W'(ea_i);
    assign pa_o       = seg_scaled + ea_ext;
endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int DSP_N = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [3:0]             mode_i,
    input  logic                   idx_sel_i,
    input  logic [OFF_W-1:0]       bx_i,
    input  logic [OFF_W-1:0]       bp_i,
    input  logic [OFF_W-1:0]       si_i,
    input  logic [OFF_W-1:0]       di_i,
    input  logic [DSP_N-1:0]       disp_lo_i,
    input  logic [OFF_W-DSP_N-1:0] disp_hi_i,
    input  logic                   disp_wide_i,
    input  logic [1:0]             acc_i,
    input  logic                   ovr_en_i,
    input  logic [1:0]             ovr_seg_i,
    input  logic [SEG_W-1:0]       es_i,
    input  logic [SEG_W-1:0]       cs_i,
    input  logic [SEG_W-1:0]       ss_i,
    input  logic [SEG_W-1:0]       ds_i,
    output logic [OFF_W-1:0]       ea_o,
    output logic [SEG_W+SHIFT-1:0] pa_o,
    output logic                   addr_vld_o,
    output logic [1:0]             seg_used_o,
    output logic                   done_o
);
    localparam int PA_W = SEG_W + SHIFT;

    typedef struct packed {
        logic [OFF_W-1:0] ea;
        logic [PA_W-1:0]  pa;
        logic             vld;
        logic [1:0]       seg;
        logic             done;
    } res_t;

    logic [OFF_W-1:0] ea_c;
    logic             ok_c;
    logic             bp_c;
    logic [1:0]       seg_c;
    logic [SEG_W-1:0] seg_vals [NUM_SEGS];
    logic [PA_W-1:0]  pa_c;
    res_t             res_d, res_q;

    assign seg_vals[SEG_ES] = es_i;
    assign seg_vals[SEG_CS] = cs_i;
    assign seg_vals[SEG_SS] = ss_i;
    assign seg_vals[SEG_DS] = ds_i;

    seg_agu_ea #(.OFF_W(OFF_W), .DSP_N(DSP_N)) u_ea (
        .mode_i      (mode_i),
        .idx_sel_i   (idx_sel_i),
        .bx_i        (bx_i),
        .bp_i        (bp_i),
        .si_i        (si_i),
        .di_i        (di_i),
        .disp_lo_i   (disp_lo_i),
        .disp_hi_i   (disp_hi_i),
        .disp_wide_i (disp_wide_i),
        .ea_o        (ea_c),
        .addr_ok_o   (ok_c),
        .bp_base_o   (bp_c)
    );

    seg_agu_segsel u_segsel (
        .acc_i     (acc_i),
        .ovr_en_i  (ovr_en_i),
        .ovr_seg_i (ovr_seg_i),
        .bp_base_i (bp_c),
        .seg_o     (seg_c)
    );

    seg_agu_pa #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_pa (
        .seg_val_i (seg_vals[seg_c]),
        .ea_i      (ea_c),
        .pa_o      (pa_c)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (start_i) begin
            res_d.ea   = ok_c ? ea_c : '0;
            res_d.pa   = ok_c ? pa_c : '0;
            res_d.vld  = ok_c;
            res_d.seg  = seg_c;
            res_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign ea_o       = res_q.ea;
    assign pa_o       = res_q.pa;
    assign addr_vld_o = res_q.vld;
    assign seg_used_o = res_q.seg;
    assign done_o     = res_q.done;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o) else $error("done missing"); // R11
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o) else $error("stray done"); // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(ea_o) && $stable(pa_o) && $stable(seg_used_o))) else $error("result moved"); // R11
    AST_FETCH_CODE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && acc_i == ACC_FETCH) |=> seg_used_o == SEG_CS) else $error("fetch seg"); // R6
    AST_BP_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && acc_i == ACC_DATA && (mode_i == AM_BP_DSP || mode_i == AM_BP_IDX_DSP || mode_i == AM_BP_IDX))
        |=> seg_used_o == SEG_SS) else $error("bp seg"); // R8
    AST_NO_OPERAND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (mode_i == AM_IMM || mode_i == AM_REG)) |=> (!addr_vld_o && pa_o == '0)) else $error("imm/reg addr"); // R10
    AST_PA_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && addr_vld_o) |-> pa_o[SHIFT-1:0] == ea_o[SHIFT-1:0]) else $error("pa nibble"); // R1

endmodule

// File: tb/seg_agu_tb.sv
module seg_agu_tb;

    typedef struct packed {
        logic [3:0]  mode;
        logic        idx;
        logic [15:0] disp;
        logic        wide;
        logic [1:0]  acc;
        logic        oen;
        logic [1:0]  oseg;
        logic [15:0] x_ea;
        logic [19:0] x_pa;
        logic        x_vld;
        logic [1:0]  x_seg;
    } vec_t;

    localparam int NV = 17;
    // Registers: bx=0100 bp=0200 si=0010 di=0020; segs es=4000 cs=1000 ss=3000 ds=2000
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b0, 16'h1234, 1'b0, 2'd0, 1'b0, 2'd0, 16'h1234, 20'h21234, 1'b1, 2'd3}, // R4 R3 direct full
        '{4'd3,  1'b0, 16'h0080, 1'b0, 2'd0, 1'b0, 2'd0, 16'hFF90, 20'h2FF90, 1'b1, 2'd3}, // R3 negative byte
        '{4'd4,  1'b1, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0020, 20'h20020, 1'b1, 2'd3}, // R5 di
        '{4'd5,  1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0100, 20'h20100, 1'b1, 2'd3}, // R4
        '{4'd6,  1'b0, 16'h7F00, 1'b1, 2'd0, 1'b0, 2'd0, 16'h8000, 20'h28000, 1'b1, 2'd3}, // R3 wide
        '{4'd7,  1'b0, 16'hFF05, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0115, 20'h20115, 1'b1, 2'd3}, // R3 hi ignored
        '{4'd8,  1'b1, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0120, 20'h20120, 1'b1, 2'd3}, // R4
        '{4'd9,  1'b0, 16'h00FE, 1'b0, 2'd0, 1'b0, 2'd0, 16'h01FE, 20'h301FE, 1'b1, 2'd2}, // R8
        '{4'd10, 1'b1, 16'h0100, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0320, 20'h30320, 1'b1, 2'd2}, // R8
        '{4'd11, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0210, 20'h30210, 1'b1, 2'd2}, // R8
        '{4'd0,  1'b0, 16'h1111, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 20'h00000, 1'b0, 2'd3}, // R10
        '{4'd1,  1'b0, 16'h2222, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 20'h00000, 1'b0, 2'd3}, // R10
        '{4'd5,  1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0100, 20'h40100, 1'b1, 2'd0}, // R9
        '{4'd9,  1'b0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0200, 20'h30200, 1'b1, 2'd2}, // R9 bp kept
        '{4'd5,  1'b0, 16'h0000, 1'b0, 2'd1, 1'b1, 2'd0, 16'h0100, 20'h10100, 1'b1, 2'd1}, // R6
        '{4'd2,  1'b0, 16'h0004, 1'b0, 2'd2, 1'b1, 2'd3, 16'h0004, 20'h30004, 1'b1, 2'd2}, // R7 stack
        '{4'd4,  1'b1, 16'h0000, 1'b0, 2'd3, 1'b1, 2'd3, 16'h0020, 20'h40020, 1'b1, 2'd0}  // R7 strdst
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic        idx_sel_i = 1'b0;
    logic [15:0] bx_i = 16'h0100, bp_i = 16'h0200, si_i = 16'h0010, di_i = 16'h0020;
    logic [7:0]  disp_lo_i = '0, disp_hi_i = '0;
    logic        disp_wide_i = 1'b0;
    logic [1:0]  acc_i = '0;
    logic        ovr_en_i = 1'b0;
    logic [1:0]  ovr_seg_i = '0;
    logic [15:0] es_i = 16'h4000, cs_i = 16'h1000, ss_i = 16'h3000, ds_i = 16'h2000;
    logic [15:0] ea_o;
    logic [19:0] pa_o;
    logic        addr_vld_o;
    logic [1:0]  seg_used_o;
    logic        done_o;

    int n_run = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    seg_agu u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .idx_sel_i(idx_sel_i), .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .disp_lo_i(disp_lo_i), .disp_hi_i(disp_hi_i), .disp_wide_i(disp_wide_i),
        .acc_i(acc_i), .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
        .es_i(es_i), .cs_i(cs_i), .ss_i(ss_i), .ds_i(ds_i),
        .ea_o(ea_o), .pa_o(pa_o), .addr_vld_o(addr_vld_o),
        .seg_used_o(seg_used_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        mode_i = v.mode; idx_sel_i = v.idx;
        disp_lo_i = v.disp[7:0]; disp_hi_i = v.disp[15:8];
        disp_wide_i = v.wide; acc_i = v.acc; ovr_en_i = v.oen; ovr_seg_i = v.oseg;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic expect_res(input string req, input vec_t v);
        chk({req, " done"}, 32'(done_o), 32'd1);
        chk({req, " ea"},   32'(ea_o), 32'(v.x_ea));
        chk({req, " pa"},   32'(pa_o), 32'(v.x_pa));
        chk({req, " vld"},  32'(addr_vld_o), 32'(v.x_vld));
        chk({req, " seg"},  32'(seg_used_o), 32'(v.x_seg));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        // R12: reset state, with a start pending during reset
        start_i = 1'b1; mode_i = 4'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 done", 32'(done_o), 32'd0);
        chk("R12 pa", 32'(pa_o), 32'd0);
        chk("R12 ea/vld/seg", {13'd0, ea_o, addr_vld_o, seg_used_o}, 32'd0);
        start_i = 1'b0;
        rst_n = 1'b1;

        // Table walk: R1 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i]);
            expect_res("R4 table", TBL[i]);
        end

        // R11: no start -> done low, results held though inputs change
        mode_i = 4'd6; disp_lo_i = 8'h55; acc_i = 2'd1;
        @(posedge clk); @(negedge clk);
        chk("R11 done drop", 32'(done_o), 32'd0);
        chk("R11 hold pa", 32'(pa_o), 32'h40020);
        chk("R11 hold ea", 32'(ea_o), 32'h0020);

        // R2: effective address wraps modulo 2^16
        bx_i = 16'hFFF0;
        v = '{4'd6, 1'b0, 16'h0020, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0010, 20'h20010, 1'b1, 2'd3};
        issue(v);
        expect_res("R2 ea wrap", v);

        // R1: physical address wraps modulo 2^20
        bx_i = 16'h0020; ds_i = 16'hFFFF;
        v = '{4'd5, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0020, 20'h00010, 1'b1, 2'd3};
        issue(v);
        expect_res("R1 pa wrap", v);

        // R10: unused code 12 gives no address
        v = '{4'd12, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0000, 20'h00000, 1'b0, 2'd3};
        issue(v);
        expect_res("R10 code12", v);

        // R11: back-to-back starts each give a done
        v = '{4'd4, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0010, 20'h00000, 1'b1, 2'd3};
        @(negedge clk);
        mode_i = 4'd4; idx_sel_i = 1'b0; ovr_en_i = 1'b0; acc_i = 2'd0; ds_i = 16'h2000;
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R11 b2b done1", 32'(done_o), 32'd1);
        chk("R11 b2b ea1", 32'(ea_o), 32'h0010);
        idx_sel_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        chk("R11 b2b done2", 32'(done_o), 32'd1);
        chk("R5 b2b ea2", 32'(ea_o), 32'h0020);
        chk("R1 b2b pa2", 32'(pa_o), 32'h20020);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule